// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers interrupt requests from a set of numbered sources and delivers them to a small number of hart contexts. Each context gets one external-interrupt line. Every source has a 3-bit priority. Every context has its own enable mask, its own priority threshold and one claim/complete register. When a context's line is high, software reads that context's claim register. The read returns the ID of the best eligible source and takes that source out of the pending set in the same cycle. When the handler has finished, software writes the same ID back to the claim register. Only after that write can the source raise a new request.

Each source passes through a gateway. Level sources are sampled while they are high. Edge sources are sampled on a rising edge, selected by a parameter mask. Once a request is sampled, it stays pending until it is claimed, even if the input drops. While a claim is outstanding, the gateway ignores the source. Source ID 0 does not exist. Registers are reached through a word-wide port with a byte address, a read strobe and a write strobe. The fixed sparse layout is described below. Reads return data combinationally in the cycle the strobe is high, and any side effect takes place at the next clock edge.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every interrupt output is low, and every priority, enable and threshold register reads 0.
- R2: The priority of source s is at byte address 4*s and holds the low 3 bits of the written value. The entry for ID 0 always reads 0 and ignores writes.
- R3: The enable mask of context c starts at 0x2000 + 0x80*c. The bit for source s is bit s%32 of word s/32. The bit for ID 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c, and its claim/complete register is at that address + 4.
- R5: The output for context c is high exactly when some source is pending, enabled in c, and has a priority strictly above c's threshold. A threshold of 7 blocks all delivery.
- R6: A source whose priority is 0 never interrupts and is never claimed. Giving it a non-zero priority lets its pending request through.
- R7: A claim read returns the eligible source with the highest priority, taking the lowest ID on a tie. It returns 0 when no source is eligible.
- R8: A claim clears the source's pending state. The source cannot become pending again until it is completed, even if its input stays high.
- R9: Writing source ID s to a context's claim register completes s only if s is enabled in that context; otherwise the write is ignored. A level source still high after completion becomes pending again one cycle later.
- R10: Sources selected in EDGE_SRC become pending only on a rising edge, and stay pending after the input falls. A rising edge while the source is claimed is dropped.
- R11: Reads from unmapped or misaligned addresses return 0, and writes to them change nothing.
- R12: A source input that is high at a clock edge raises the eligible context's output right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC-1 | Request inputs, bit s for source ID s (1..NUM_SRC-1) |
| addr_i | input | ADDR_W | Byte address of the register access |
| re_i | input | 1 | Read strobe; on a claim address it claims at the edge |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid combinationally while re_i is high |
| irq_o | output | NUM_CTX | External-interrupt request, one per context |

## Verification
Corrupted gateway state shows up in two ways. If a pending bit is lost, the output stays low and the claim read returns 0. If a source fails to stay blocked, the same ID is returned a second time before it is completed. Either is visible on the first claim read after the bad edge. Arbiter faults change the ID that a claim returns in that same read. Threshold or enable faults flip irq_o one cycle after the register write. For that reason, each check samples the output at most two edges after the stimulus.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int PRIO_W    = 3;
  localparam int EN_WBASE  = 'h2000 / 4;    // enable region, word address
  localparam int EN_WSTEP  = 'h80 / 4;      // words per context enable block
  localparam int CX_WBASE  = 'h200000 / 4;  // context control region, word address
  localparam int CX_WSTEP  = 'h1000 / 4;
  localparam int THR_WOFS  = 0;
  localparam int CLM_WOFS  = 1;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);
  logic prev_q, sample;

  assign sample = EDGE ? (req_i & ~prev_q) : req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      prev_q <= req_i;
      if (claim_i) begin
        pend_o <= 1'b0;
        busy_o <= 1'b1;
      end else begin
        if (done_i) busy_o <= 1'b0;
        if (sample && !busy_o) pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]         pend_i,
  input  logic [NUM_SRC-1:0]         en_i,
  input  prio_t [NUM_SRC-1:0]        prio_i,
  input  prio_t                      thr_i,
  output logic [ID_W-1:0]            id_o,
  output logic                       irq_o
);
  prio_t best_p;

  // strict compare: keeps lowest ID on ties and enforces prio > threshold
  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && prio_i[i] > best_p) begin
        best_p = prio_i[i];
        id_o   = ID_W'(i);
      end
    end
  end

  assign irq_o = (id_o != '0);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26,
  localparam int ID_W     = $clog2(NUM_SRC),
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int WA_W     = ADDR_W - 2,
  localparam int EN_WORDS = (NUM_SRC + 31) / 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             re_i,
  input  logic                             we_i,
  input  logic [31:0]                      wdata_i,
  output logic [31:0]                      rdata_o,
  input  logic [NUM_CTX-1:0][ID_W-1:0]     win_i,
  output prio_t [NUM_SRC-1:0]              prio_o,
  output logic [NUM_CTX-1:0][NUM_SRC-1:0]  en_o,
  output prio_t [NUM_CTX-1:0]              thr_o,
  output logic [NUM_SRC-1:1]               claim_o,
  output logic [NUM_SRC-1:1]               done_o
);
  logic [WA_W-1:0]  word, en_woff, cx_woff, en_ctx_f, cx_ctx_f;
  logic             aligned, prio_sel, en_sel, cx_sel, thr_sel, clm_sel;
  logic [CTX_W-1:0] en_ctx, cx_ctx;
  logic [4:0]       en_wrd;

  assign word     = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign en_woff  = word - WA_W'(EN_WBASE);
  assign cx_woff  = word - WA_W'(CX_WBASE);
  assign en_ctx_f = en_woff / WA_W'(EN_WSTEP);
  assign cx_ctx_f = cx_woff / WA_W'(CX_WSTEP);
  assign en_ctx   = en_ctx_f[CTX_W-1:0];
  assign cx_ctx   = cx_ctx_f[CTX_W-1:0];
  assign en_wrd   = en_woff[4:0];

  assign prio_sel = aligned && word < WA_W'(NUM_SRC);
  assign en_sel   = aligned && word >= WA_W'(EN_WBASE) && en_ctx_f < WA_W'(NUM_CTX)
                    && en_wrd < 5'(EN_WORDS);
  assign cx_sel   = aligned && word >= WA_W'(CX_WBASE) && cx_ctx_f < WA_W'(NUM_CTX);
  assign thr_sel  = cx_sel && cx_woff[9:0] == 10'(THR_WOFS);
  assign clm_sel  = cx_sel && cx_woff[9:0] == 10'(CLM_WOFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_o <= '0;
      en_o   <= '0;
      thr_o  <= '0;
    end else if (we_i) begin
      if (prio_sel && word[ID_W-1:0] != '0) prio_o[word[ID_W-1:0]] <= wdata_i[PRIO_W-1:0];
      if (thr_sel) thr_o[cx_ctx] <= wdata_i[PRIO_W-1:0];
      for (int s = 1; s < NUM_SRC; s++) begin
        if (en_sel && en_wrd == 5'(s / 32)) en_o[en_ctx][s] <= wdata_i[s % 32];
      end
    end
  end

  always_comb begin
    claim_o = '0;
    done_o  = '0;
    for (int s = 1; s < NUM_SRC; s++) begin
      claim_o[s] = re_i && clm_sel && win_i[cx_ctx] == ID_W'(s);
      done_o[s]  = we_i && clm_sel && wdata_i == 32'(s) && en_o[cx_ctx][s];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (prio_sel) rdata_o = 32'(prio_o[word[ID_W-1:0]]);
    else if (en_sel) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (en_wrd == 5'(s / 32)) rdata_o[s % 32] = en_o[en_ctx][s];
      end
    end
    else if (thr_sel) rdata_o = 32'(thr_o[cx_ctx]);
    else if (clm_sel) rdata_o = 32'(win_i[cx_ctx]);
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int                  NUM_SRC  = 32,
  parameter int                  NUM_CTX  = 2,
  parameter int                  ADDR_W   = 26,
  parameter logic [NUM_SRC-1:0]  EDGE_SRC = 32'h0000_00F0,
  localparam int                 ID_W     = $clog2(NUM_SRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:1]   src_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 re_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CTX-1:0]   irq_o
);
  prio_t [NUM_SRC-1:0]             prio;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en;
  prio_t [NUM_CTX-1:0]             thr;
  logic [NUM_CTX-1:0][ID_W-1:0]    win;
  logic [NUM_SRC-1:1]              claim, done;
  logic [NUM_SRC-1:0]              pend, busy;

  irq_regfile #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .re_i, .we_i, .wdata_i, .rdata_o,
    .win_i(win), .prio_o(prio), .en_o(en), .thr_o(thr),
    .claim_o(claim), .done_o(done)
  );

  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;

  for (genvar s = 1; s < NUM_SRC; s++) begin : g_gw
    irq_gateway #(.EDGE(EDGE_SRC[s])) u_gw (
      .clk_i, .rst_ni, .req_i(src_i[s]), .claim_i(claim[s]), .done_i(done[s]),
      .pend_o(pend[s]), .busy_o(busy[s])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .pend_i(pend), .en_i(en[c]), .prio_i(prio), .thr_i(thr[c]),
      .id_o(win[c]), .irq_o(irq_o[c])
    );
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   re_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [31:0]            rdata_o,
  input logic [NUM_CTX-1:0]     irq_o,
  input logic [NUM_SRC-1:0]     pend,
  input logic [NUM_SRC-1:0]     busy,
  input logic [NUM_SRC*3-1:0]   prio_flat,
  input logic [NUM_CTX*3-1:0]   thr_flat
);
  logic [NUM_CTX-1:0] clm_rd;
  logic [ID_W-1:0]    rid;

  assign rid = rdata_o[ID_W-1:0];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
    assign clm_rd[c] = re_i && addr_i == ADDR_W'('h200000 + 'h1000 * c + 4);

    // R5: threshold 7 blocks delivery
    a_r5_thr_max_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr_flat[c*3 +: 3] == 3'd7 |-> !irq_o[c]);

    // R7: claim yields an ID exactly when the line is raised
    a_r7_claim_matches_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clm_rd[c] |-> (irq_o[c] == (rdata_o != 0)) && rdata_o < NUM_SRC);
  end

  // R8: a claimed source is never pending at the same time
  a_r8_pend_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & busy) == '0);

  // R8: claim clears pending and marks in flight
  a_r8_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clm_rd && rdata_o != 0) |=> busy[$past(rid)] && !pend[$past(rid)]);

  // R6: priority 0 is never claimed
  a_r6_claim_prio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clm_rd && rdata_o != 0) |-> prio_flat[rid*3 +: 3] != 3'd0);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .re_i(re_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .pend(pend), .busy(busy), .prio_flat(prio), .thr_flat(thr)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int NS = 32, NC = 2, AW = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NS-1:1] src = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [31:0]   wdata = '0, rdata;
  logic [NC-1:0] irq;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;
  logic [31:0]   exp_q[$];
  string         tag_q[$];

  ext_irq_ctrl #(.NUM_SRC(NS), .NUM_CTX(NC), .ADDR_W(AW), .EDGE_SRC(32'h0000_00F0)) u_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .re_i(re), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] a_prio(int id); return AW'(4 * id); endfunction
  function automatic logic [AW-1:0] a_en(int c);    return AW'('h2000 + 'h80 * c); endfunction
  function automatic logic [AW-1:0] a_thr(int c);   return AW'('h200000 + 'h1000 * c); endfunction
  function automatic logic [AW-1:0] a_clm(int c);   return AW'('h200000 + 'h1000 * c + 4); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
    step();
  endtask

  // driver: push expectation, then issue the read
  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; re = 1'b1;
    step();
    re = 1'b0;
    step();
  endtask

  task automatic chk_irq(int c, logic exp, string tag);
    @(negedge clk);
    chk(tag, 32'(irq[c]), 32'(exp));
    step();
  endtask

  // monitor: compare read data against scoreboard
  always @(negedge clk) begin
    if (re) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd(a_prio(3), 0, "R1 prio reset");
    rd(a_en(0),   0, "R1 enable reset");
    rd(a_thr(1),  0, "R1 threshold reset");
    // R2 priority registers
    wr(a_prio(3), 5);          rd(a_prio(3), 5, "R2 prio readback");
    wr(a_prio(3), 32'hF);      rd(a_prio(3), 7, "R2 prio 3-bit field");
    wr(a_prio(0), 3);          rd(a_prio(0), 0, "R2 id0 prio hardwired");
    wr(a_prio(3), 5);
    // R3 enable layout
    wr(a_en(0), 32'hFFFF_FFFF); rd(a_en(0), 32'hFFFF_FFFE, "R3 enable bit0 hardwired");
    wr(a_en(1), 32'h0000_0200); rd(a_en(1), 32'h0000_0200, "R3 ctx1 enable");
    // R11 unmapped
    rd(AW'('h1000), 0, "R11 gap read");
    wr(AW'('h1000), 7); rd(AW'('h1000), 0, "R11 gap write");
    rd(a_en(2), 0, "R11 missing context enable");
    rd(AW'('h2004), 0, "R11 enable word beyond sources");
    wr(a_thr(0) + 8, 5); rd(a_thr(0) + 8, 0, "R11 ctx hole");
    rd(a_thr(0), 0, "R11 hole write no effect");
    wr(a_prio(3) + 1, 2); rd(a_prio(3), 5, "R11 misaligned write ignored");
    // R4 context layout
    wr(a_thr(1), 5); rd(a_thr(1), 5, "R4 ctx1 threshold");
    rd(a_thr(0), 0, "R4 ctx0 threshold separate");
    wr(a_prio(9), 5); wr(a_prio(12), 6);
    // R12 latency
    src[12] = 1'b1;
    @(negedge clk); chk("R12 irq before edge", 32'(irq[0]), 0);
    @(negedge clk); chk("R12 irq one edge later", 32'(irq[0]), 1);
    step();
    // R5/R7/R8 arbitration and claim
    src[3] = 1'b1; src[9] = 1'b1;
    step(2);
    chk_irq(1, 1'b0, "R5 equal to threshold not delivered");
    rd(a_clm(0), 12, "R7 highest priority");
    rd(a_clm(0), 3,  "R7 tie lowest id");
    rd(a_clm(0), 9,  "R7 next");
    rd(a_clm(0), 0,  "R7 none left");
    chk_irq(0, 1'b0, "R8 claimed sources held off");
    // R9 completion
    wr(a_clm(0), 3);
    rd(a_clm(0), 3, "R9 level re-pends after complete");
    src[3] = 1'b0; src[12] = 1'b0;
    wr(a_clm(0), 3); wr(a_clm(0), 12);
    wr(a_clm(1), 9);
    rd(a_clm(1), 0, "R5 ctx1 threshold blocks");
    wr(a_thr(1), 0);
    chk_irq(1, 1'b1, "R4 ctx1 irq");
    rd(a_clm(1), 9, "R4 ctx1 claim");
    src[9] = 1'b0;
    wr(a_clm(1), 9);
    // R6 priority zero masks
    wr(a_prio(20), 0);
    src[20] = 1'b1;
    step(2);
    chk_irq(0, 1'b0, "R6 prio0 no irq");
    rd(a_clm(0), 0, "R6 prio0 not claimed");
    wr(a_prio(20), 2);
    chk_irq(0, 1'b1, "R6 unmask delivers");
    rd(a_clm(0), 20, "R6 unmask claim");
    src[20] = 1'b0;
    wr(a_clm(1), 20);   // not enabled in ctx1: ignored
    src[20] = 1'b1;
    step(2);
    chk_irq(0, 1'b0, "R9 foreign completion ignored");
    rd(a_clm(0), 0, "R9 still in flight");
    wr(a_clm(0), 20);
    rd(a_clm(0), 20, "R9 proper completion");
    src[20] = 1'b0;
    wr(a_clm(0), 20);
    // R5 thresholds
    src[12] = 1'b1;
    wr(a_thr(0), 6); chk_irq(0, 1'b0, "R5 prio equal threshold");
    wr(a_thr(0), 5); chk_irq(0, 1'b1, "R5 prio above threshold");
    wr(a_thr(0), 7); chk_irq(0, 1'b0, "R5 threshold 7 blocks");
    wr(a_thr(0), 0);
    rd(a_clm(0), 12, "R5 claim after threshold lowered");
    src[12] = 1'b0;
    wr(a_clm(0), 12);
    // R10 edge source
    wr(a_prio(5), 4);
    src[5] = 1'b1; step(); src[5] = 1'b0; step();
    chk_irq(0, 1'b1, "R10 edge latched after fall");
    rd(a_clm(0), 5, "R10 edge claim");
    src[5] = 1'b1; step(2);
    wr(a_clm(0), 5);
    chk_irq(0, 1'b0, "R10 held high no retrigger");
    rd(a_clm(0), 0, "R10 no claim without new edge");
    src[5] = 1'b0; step(); src[5] = 1'b1; step();
    rd(a_clm(0), 5, "R10 new edge");
    src[5] = 1'b0;
    wr(a_clm(0), 5);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule